// File: doc/BRIEF.md
# Pairable Four-Channel Pulse-Width Modulator

The block drives four pulse-width-modulated pins from four 8-bit channels. Each channel has a free-running counter, a period register and a duty register. A byte-wide register bus reaches all of them. A channel's pin is high while its counter is below its duty value. Its counter returns to zero on the tick after it reaches the period value.

A control byte can join channels 1 and 2, or channels 3 and 4, into one 16-bit channel. In a joined pair the odd channel holds the upper byte of the counter, period and duty, and the even channel holds the lower byte. The waveform comes out on the even channel's pin. The odd pin is then parked low and flagged as free for general-purpose use.

A read of the upper counter byte freezes the lower byte for one cycle, so a two-byte read sees one consistent value. A write of any value to the lower counter byte clears the counter. The counters advance on enables derived from an input tick. A power-of-two divider, chosen per pair in the control byte, sets the rate.

Top module: `pwm4_cat`

## Requirements
- R1: The control byte (address 0) resets to 0x00 and reads back what was last written. Its layout is: bit 7 joins channels 3/4, bit 6 joins channels 1/2, bits 5:3 select the divider for channels 1/2, and bits 2:0 select the divider for channels 3/4.
- R2: A separate channel's pin is high exactly while its 8-bit counter is less than its duty byte. The counter steps by one per enabled tick and goes to 0 on the tick after it equals (or exceeds) the period, giving a cycle of period+1 ticks.
- R3: In a joined pair, counting, wrap and compare use the 16-bit values {odd channel byte, even channel byte} for counter, period and duty.
- R4: In a joined pair the even channel's pin carries the 16-bit waveform. The odd channel's pin is held low and its free flag is 1. Every other free flag is 0. Flag bit i belongs to channel i+1.
- R5: A base-tick count runs from reset. A pair whose divider select is n advances its counters only on base ticks where the low n bits of that count are zero, so it advances once every 2^n base ticks.
- R6: In a joined pair, reading the odd (upper) counter byte captures the even (lower) counter byte. A read of the lower byte in the very next cycle returns the captured value, even if the counter moved meanwhile.
- R7: A lower-byte counter read that does not come in the cycle right after an upper-byte read returns the live counter byte.
- R8: A write of any value to a channel's counter address clears that channel's counter. In a joined pair, a write to the lower byte clears the full 16-bit counter.
- R9: In a joined pair, writes to the upper counter byte leave the counter unchanged.
- R10: Bus map: the counters of channels 1 to 4 sit at addresses 1 to 4, the periods at 5 to 8 and the duties at 9 to 12. Period and duty read back as written. Unmapped addresses read 0. Read data appears on the clock edge that samples the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_tick_i | input | 1 | Prescaler input enable, one pulse per base tick |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, registered |
| pwm_o | output | 4 | PWM pins, bit i is channel i+1 |
| pin_free_o | output | 4 | Pin released for general-purpose use, bit i is channel i+1 |

## Verification
Channel 1 alone is stepped through two full cycles with a short period. This separates the below-duty compare from an at-or-below compare and places the wrap on the correct tick. The joined pair is run across its duty edge and its 16-bit wrap, which shows that both bytes take part in the compare. An upper-byte read is made in the same cycle as a tick that carries the lower byte from 0xFF to 0x00. This tells the captured byte apart from the live one, and a later read with a tick in the gap shows the capture has expired. A divided channel is counted against base ticks whose phase is known, which pins down both the rate and the alignment.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;

    localparam int NUM_CH    = 4;
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_CNT0 = 1;

    // capture state of the lower counter byte for one pair
    typedef enum logic [0:0] {
        SNAP_LIVE = 1'b0,
        SNAP_HELD = 1'b1
    } snap_state_e;

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick_i,
    input  logic [SEL_W-1:0] sel_a_i,
    input  logic [SEL_W-1:0] sel_b_i,
    output logic             tick_a_o,
    output logic             tick_b_o
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_q;

    function automatic logic [DIV_W-1:0] low_mask(input logic [SEL_W-1:0] s);
        logic [DIV_W:0] m;
        m = ({{DIV_W{1'b0}}, 1'b1} << s) - {{DIV_W{1'b0}}, 1'b1};
        return m[DIV_W-1:0];
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (base_tick_i) begin
            div_q <= div_q + {{(DIV_W-1){1'b0}}, 1'b1};
        end
    end

    assign tick_a_o = base_tick_i && ((div_q & low_mask(sel_a_i)) == '0);
    assign tick_b_o = base_tick_i && ((div_q & low_mask(sel_b_i)) == '0);

endmodule

// File: rtl/pwm_snap.sv
module pwm_snap
    import pwm4_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture_i,
    input  logic [W-1:0] live_i,
    output logic         held_o,
    output logic [W-1:0] hold_o
);
    snap_state_e  state_q, state_d;
    logic [W-1:0] hold_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SNAP_LIVE: state_d = capture_i ? SNAP_HELD : SNAP_LIVE;  // arm
            SNAP_HELD: state_d = capture_i ? SNAP_HELD : SNAP_LIVE;  // re-arm or expire
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SNAP_LIVE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (capture_i) begin
                hold_q <= live_i;
            end
        end
    end

    always_comb begin
        held_o = (state_q == SNAP_HELD);
        hold_o = hold_q;
    end

endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         join_i,
    input  logic         clr_hi_i,
    input  logic         clr_lo_i,
    input  logic [W-1:0] per_hi_i,
    input  logic [W-1:0] per_lo_i,
    input  logic [W-1:0] duty_hi_i,
    input  logic [W-1:0] duty_lo_i,
    output logic [W-1:0] cnt_hi_o,
    output logic [W-1:0] cnt_lo_o,
    output logic         pwm_hi_o,
    output logic         pwm_lo_o,
    output logic         free_hi_o
);
    localparam int W2 = 2 * W;

    logic [W-1:0]  hi_q, lo_q, hi_d, lo_d;
    logic [W2-1:0] cnt16, per16, duty16;

    assign cnt16  = {hi_q, lo_q};
    assign per16  = {per_hi_i, per_lo_i};
    assign duty16 = {duty_hi_i, duty_lo_i};

    always_comb begin
        hi_d = hi_q;
        lo_d = lo_q;
        if (join_i) begin
            if (clr_lo_i) begin
                {hi_d, lo_d} = '0;
            end else if (tick_i) begin
                {hi_d, lo_d} = (cnt16 >= per16) ? '0 : cnt16 + W2'(1);
            end
        end else begin
            if (clr_hi_i) begin
                hi_d = '0;
            end else if (tick_i) begin
                hi_d = (hi_q >= per_hi_i) ? '0 : hi_q + W'(1);
            end
            if (clr_lo_i) begin
                lo_d = '0;
            end else if (tick_i) begin
                lo_d = (lo_q >= per_lo_i) ? '0 : lo_q + W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    always_comb begin
        cnt_hi_o  = hi_q;
        cnt_lo_o  = lo_q;
        free_hi_o = join_i;
        pwm_hi_o  = !join_i && (hi_q < duty_hi_i);
        pwm_lo_o  = join_i ? (cnt16 < duty16) : (lo_q < duty_lo_i);
    end

endmodule

// File: rtl/pwm4_cat.sv
module pwm4_cat
    import pwm4_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BYTE_W-1:0] bus_wdata_i,
    output logic [BYTE_W-1:0] bus_rdata_o,
    output logic [NUM_CH-1:0] pwm_o,
    output logic [NUM_CH-1:0] pin_free_o
);
    localparam int CH       = NUM_CH;
    localparam int PAIRS    = CH / 2;
    localparam int PER0     = ADDR_CNT0 + CH;
    localparam int DUTY0    = PER0 + CH;
    localparam int JOIN_LSB = 2 * SEL_W;

    logic [BYTE_W-1:0]                ctrl_q;
    logic [CH-1:0][BYTE_W-1:0]        per_q, duty_q, cnt_q;
    logic [BYTE_W-1:0]                rdata_q, rd_val;
    logic [PAIRS-1:0]                 join_w, tick_w, snap_held;
    logic [PAIRS-1:0][BYTE_W-1:0]     snap_val;
    logic [CH-1:0]                    wr_cnt;
    logic                             tick_a, tick_b;

    assign join_w = ctrl_q[JOIN_LSB +: PAIRS];

    // register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            per_q  <= '0;
            duty_q <= '0;
        end else if (bus_wr_i) begin
            if (bus_addr_i == ADDR_W'(ADDR_CTRL)) begin
                ctrl_q <= bus_wdata_i;
            end
            for (int i = 0; i < CH; i++) begin
                if (bus_addr_i == ADDR_W'(PER0 + i))  per_q[i]  <= bus_wdata_i;
                if (bus_addr_i == ADDR_W'(DUTY0 + i)) duty_q[i] <= bus_wdata_i;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < CH; i++) begin
            wr_cnt[i] = bus_wr_i && (bus_addr_i == ADDR_W'(ADDR_CNT0 + i));
        end
    end

    pwm_prescale #(.SEL_W(SEL_W)) u_presc (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_tick_i (base_tick_i),
        .sel_a_i     (ctrl_q[2*SEL_W-1 -: SEL_W]),
        .sel_b_i     (ctrl_q[SEL_W-1:0]),
        .tick_a_o    (tick_a),
        .tick_b_o    (tick_b)
    );

    assign tick_w = {tick_b, tick_a};

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        logic cap;
        assign cap = bus_rd_i && join_w[p]
                  && (bus_addr_i == ADDR_W'(ADDR_CNT0 + 2*p));

        pwm_pair #(.W(BYTE_W)) u_pair (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (tick_w[p]),
            .join_i    (join_w[p]),
            .clr_hi_i  (wr_cnt[2*p]),
            .clr_lo_i  (wr_cnt[2*p+1]),
            .per_hi_i  (per_q[2*p]),
            .per_lo_i  (per_q[2*p+1]),
            .duty_hi_i (duty_q[2*p]),
            .duty_lo_i (duty_q[2*p+1]),
            .cnt_hi_o  (cnt_q[2*p]),
            .cnt_lo_o  (cnt_q[2*p+1]),
            .pwm_hi_o  (pwm_o[2*p]),
            .pwm_lo_o  (pwm_o[2*p+1]),
            .free_hi_o (pin_free_o[2*p])
        );

        assign pin_free_o[2*p+1] = 1'b0;

        pwm_snap #(.W(BYTE_W)) u_snap (
            .clk       (clk),
            .rst_n     (rst_n),
            .capture_i (cap),
            .live_i    (cnt_q[2*p+1]),
            .held_o    (snap_held[p]),
            .hold_o    (snap_val[p])
        );
    end

    // read path
    always_comb begin
        rd_val = '0;
        if (bus_addr_i == ADDR_W'(ADDR_CTRL)) rd_val = ctrl_q;
        for (int i = 0; i < CH; i++) begin
            if (bus_addr_i == ADDR_W'(ADDR_CNT0 + i)) begin
                rd_val = ((i % 2 == 1) && snap_held[i/2]) ? snap_val[i/2] : cnt_q[i];
            end
            if (bus_addr_i == ADDR_W'(PER0 + i))  rd_val = per_q[i];
            if (bus_addr_i == ADDR_W'(DUTY0 + i)) rd_val = duty_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd_i) begin
            rdata_q <= rd_val;
        end
    end

    assign bus_rdata_o = rdata_q;

endmodule

// File: rtl/pwm4_cat_chk.sv
module pwm4_cat_chk
    import pwm4_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4,
    parameter int SEL_W  = 3
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            base_tick_i,
    input logic                            bus_wr_i,
    input logic                            bus_rd_i,
    input logic [ADDR_W-1:0]               bus_addr_i,
    input logic [BYTE_W-1:0]               bus_rdata_o,
    input logic [NUM_CH-1:0]               pwm_o,
    input logic [NUM_CH-1:0]               pin_free_o,
    input logic [BYTE_W-1:0]               ctrl_q,
    input logic [NUM_CH-1:0][BYTE_W-1:0]   cnt_q
);
    localparam int J12 = 2 * SEL_W;
    localparam int J34 = 2 * SEL_W + 1;

    a_r4_even_never_free: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_free_o[1] && !pin_free_o[3]);

    a_r4_odd_free_follows_join: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_free_o[0] == ctrl_q[J12]) && (pin_free_o[2] == ctrl_q[J34]));

    a_r4_odd_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[J12] |-> !pwm_o[0]);

    a_r8_low_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == ADDR_W'(ADDR_CNT0 + 1))
        |=> (cnt_q[1] == '0) && (!$past(ctrl_q[J12]) || cnt_q[0] == '0));

    a_r9_high_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == ADDR_W'(ADDR_CNT0) && ctrl_q[J12] && !base_tick_i)
        |=> cnt_q[0] == $past(cnt_q[0]));

    a_r6_snapshot_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == ADDR_W'(ADDR_CNT0 + 1)
         && $past(bus_rd_i && bus_addr_i == ADDR_W'(ADDR_CNT0) && ctrl_q[J12]))
        |=> bus_rdata_o == $past(cnt_q[1], 2));

endmodule

bind pwm4_cat pwm4_cat_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .base_tick_i (base_tick_i),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .pwm_o       (pwm_o),
    .pin_free_o  (pin_free_o),
    .ctrl_q      (ctrl_q),
    .cnt_q       (cnt_q)
);

// File: tb/tb_pwm4_cat.sv
`timescale 1ns/100ps
module tb_pwm4_cat;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] pwm;
    logic [3:0] pin_free;

    int tests = 0;
    int fails = 0;
    int total_ticks = 0;
    int exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    pwm4_cat dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_tick_i (base_tick),
        .bus_wr_i    (bus_wr),
        .bus_rd_i    (bus_rd),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .pwm_o       (pwm),
        .pin_free_o  (pin_free)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: issue read, push expected item to the scoreboard
    task automatic bus_read(input logic [3:0] a, input int exp, input string tag,
                            input bit with_tick = 1'b0);
        bus_rd = 1'b1; bus_addr = a; base_tick = with_tick;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0; base_tick = 1'b0;
        if (with_tick) total_ticks++;
    endtask

    task automatic ticks(input int n);
        base_tick = 1'b1;
        repeat (n) @(negedge clk);
        base_tick = 1'b0;
        total_ticks += n;
    endtask

    function automatic int div4_steps(input int t0, input int n);
        int c = 0;
        for (int t = t0; t < t0 + n; t++) if (t % 4 == 0) c++;
        return c;
    endfunction

    // monitor: pop and compare as read data is produced
    initial begin
        bit fire;
        int e;
        string t;
        forever begin
            @(posedge clk);
            fire = bus_rd;
            #1;
            if (fire) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_rdata == e[7:0], t, int'(bus_rdata), e);
            end
        end
    end

    initial begin
        #1000000;
        tests++; fails++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(pin_free == 4'b0000, "R1 R4 free flags after reset", int'(pin_free), 0);
        check(pwm == 4'b0000, "R1 R2 pins after reset", int'(pwm), 0);
        bus_read(4'd0, 8'h00, "R1 control after reset");

        // R2 separate channel 1: period 4, duty 2; channel 2 period 0xFF
        bus_write(4'd6, 8'hFF);
        bus_write(4'd5, 8'd4);
        bus_write(4'd9, 8'd2);
        bus_write(4'd1, 8'hA5);
        for (int k = 0; k < 10; k++) begin
            bus_read(4'd1, k % 5, "R2 channel 1 count");
            check(pwm[0] == ((k % 5) < 2), "R2 channel 1 pin", int'(pwm[0]), int'((k % 5) < 2));
            ticks(1);
        end
        ticks(3);
        bus_read(4'd2, 13, "R2 channel 2 count");
        bus_write(4'd2, 8'h00);
        bus_read(4'd2, 0, "R8 channel 2 cleared");
        bus_read(4'd1, 3, "R8 channel 1 untouched");
        bus_write(4'd1, 8'h3C);
        bus_read(4'd1, 0, "R8 channel 1 cleared");

        // R10 map
        bus_read(4'd5, 4, "R10 period readback");
        bus_read(4'd9, 2, "R10 duty readback");
        bus_read(4'd15, 0, "R10 unmapped address");

        // R5 divider 2 on channels 3/4
        bus_write(4'd0, 8'h02);
        bus_read(4'd0, 8'h02, "R1 control readback");
        bus_write(4'd7, 8'hFF);
        bus_write(4'd3, 8'h00);
        t0 = total_ticks;
        ticks(10);
        bus_read(4'd3, div4_steps(t0, 10), "R5 divided count");
        ticks(7);
        bus_read(4'd3, div4_steps(t0, 17), "R5 divided count later");

        // R3/R4 join channels 1/2: period 0x0102, duty 0x0080
        bus_write(4'd0, 8'h40);
        check(pin_free == 4'b0001, "R4 free flags joined 1/2", int'(pin_free), 1);
        bus_write(4'd5, 8'h01);
        bus_write(4'd6, 8'h02);
        bus_write(4'd9, 8'h00);
        bus_write(4'd10, 8'h80);
        bus_write(4'd2, 8'h77);
        ticks(127);
        check(pwm[1] == 1'b1, "R3 below 16-bit duty", int'(pwm[1]), 1);
        check(pwm[0] == 1'b0, "R4 odd pin quiet", int'(pwm[0]), 0);
        ticks(1);
        check(pwm[1] == 1'b0, "R3 at 16-bit duty", int'(pwm[1]), 0);
        ticks(130);
        bus_read(4'd1, 8'h01, "R3 upper byte at period");
        bus_read(4'd2, 8'h02, "R3 lower byte at period");
        ticks(1);
        check(pwm[1] == 1'b1, "R3 16-bit wrap", int'(pwm[1]), 1);

        // R6/R7 coherent read
        ticks(255);
        bus_read(4'd1, 8'h00, "R6 upper byte", 1'b1);
        bus_read(4'd2, 8'hFF, "R6 lower byte from capture");
        bus_read(4'd2, 8'h00, "R7 lower byte live");
        bus_read(4'd1, 8'h01, "R7 upper byte");
        ticks(1);
        bus_read(4'd2, 8'h01, "R7 capture expired");

        // R9 upper write ignored
        bus_write(4'd1, 8'h55);
        bus_read(4'd1, 8'h01, "R9 upper unchanged");
        bus_read(4'd2, 8'h01, "R9 lower unchanged");

        // R8 joined clear
        bus_write(4'd2, 8'hEE);
        bus_read(4'd1, 8'h00, "R8 pair upper cleared");
        bus_read(4'd2, 8'h00, "R8 pair lower cleared");

        // R4 both pairs joined
        bus_write(4'd0, 8'hC0);
        check(pin_free == 4'b0101, "R4 free flags both joined", int'(pin_free), 5);
        check(pwm[2] == 1'b0, "R4 channel 3 pin quiet", int'(pwm[2]), 0);
        bus_read(4'd0, 8'hC0, "R1 control both joins");
        bus_write(4'd0, 8'h00);
        check(pin_free == 4'b0000, "R4 free flags released", int'(pin_free), 0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule